// File: doc/BRIEF.md
# Three-Level Interrupt Status Tree

This block collects a wide bank of raw interrupt lines and presents them to a host as a tree of status registers on a small synchronous register bus with a 10-bit address and 8-bit data. Lines are grouped eight to a block. Blocks are grouped eight to a master. A single root register names the masters that have work, and one summary interrupt output tells the host that the root is non-zero.

Each line has its own trigger settings. In edge mode it can catch rising edges, falling edges, or both. In level mode it can be active-high or active-low. Detection uses the line's two-flop synchronized level.

Software reaches per-line state through an indirect window. It writes a block number to a select register. The pending, configuration and live-level registers then act on that block. Each configuration byte carries a write-enable bit and the index of the target line inside the selected block, so one write sets up or clears exactly one line.

Top module: `irq_tree_agg`

## Requirements
- R1: After reset every line is in edge mode with both masks set, nothing is pending, the block-select register reads 0 and irq_out is 0.
- R2: Reads of any address below BASE or above BASE+8 return 0. Bit 0 of the root register (BASE) always reads 0.
- R3: A write to BASE+5 stores the low 5 bits of wdata as the selected block, and BASE+5 reads that value back. BASE+6 and BASE+8 return the eight lines of the selected block, with bit i standing for line block*8+i.
- R4: A write to the configuration register (BASE+7) with wdata bit 7 at 0 changes no line setting and clears nothing.
- R5: The fields of a configuration write to BASE+7 with bit 7 set are:
  - bits 6:4 give the line index within the selected block;
  - bit 2 set masks rising-edge or high-level detection;
  - bit 1 set masks falling-edge or low-level detection;
  - bit 0 selects level mode (1) or edge mode (0).

  In edge mode, each enabled edge of the synchronized input sets the line's pending flag. Rising and falling detection may both be enabled.
- R6: In level mode, with only the rising mask clear, a high input keeps the pending flag set. With only the falling mask clear, a low input keeps it set. If the line is still active after a clear, the flag sets again one cycle later.
- R7: A configuration write with bits 7 and 3 set clears the pending flag of the addressed line in the next cycle.
- R8: A line with both masks set keeps its pending flag readable at BASE+6, but adds nothing to the master summaries, the root or irq_out.
- R9: Bit i of the master register at BASE+1+m is set when block m*8+i holds a pending line that is not fully masked. Root bit m+1 is the OR of master m. irq_out is the OR of the root bits.
- R10: BASE+8 returns the present synchronized levels of the selected block's lines, whatever their pending state.
- R11: A pending flag stays set until a clearing configuration write addresses its line, even after the input returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| addr | input | 10 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_out | output | 1 | Summary interrupt to the host |

## Verification
The assertions check on every cycle the properties that do not depend on the input history:
- out-of-window and root bit 0 reads are zero;
- a block-select write takes effect;
- a configuration write without its enable bit leaves the masks alone;
- an addressed clear empties the flag;
- no flag falls without a clear;
- irq_out stays low while nothing is pending.

Only the bench scenarios can show the rest, because each needs a stimulus history:
- that an enabled edge or level actually raises a flag;
- that a still-active level line re-pends after a clear;
- that fully masked lines vanish from the summaries while their live level still reads;
- that the master and root bits land on the right positions for lines across the whole range.

// File: rtl/irq_tree_agg.sv
module irq_tree_agg #(
  parameter int         NUM_LINES = 256,
  parameter logic [9:0] BASE      = 10'h1BB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [9:0]           addr,
  input  logic                 wr_en,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 irq_out
);
  localparam int NBLK = NUM_LINES / 8;
  localparam int NMST = (NBLK + 7) / 8;
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int LW   = BW + 3;
  localparam logic [9:0] A_SEL  = BASE + 10'd5;
  localparam logic [9:0] A_PEND = BASE + 10'd6;
  localparam logic [9:0] A_CFG  = BASE + 10'd7;
  localparam logic [9:0] A_RT   = BASE + 10'd8;

  logic [NUM_LINES-1:0] s1, s2, prev, lvl, mre, mfe, pend;
  logic [BW-1:0]        blk_sel;
  logic [NMST*8-1:0]    blk_any;
  logic [NMST-1:0]      mst;

  wire                 sel_wr   = wr_en && (addr == A_SEL);
  wire                 cfg_wr   = wr_en && (addr == A_CFG) && wdata[7];
  wire [LW-1:0]        line_idx = {blk_sel, wdata[6:4]};
  wire [NUM_LINES-1:0] hit      = cfg_wr ? (NUM_LINES'(1) << line_idx) : '0;
  wire [NUM_LINES-1:0] clr      = hit & {NUM_LINES{wdata[3]}};
  wire [NUM_LINES-1:0] live     = pend & ~(mre & mfe);

  wire [NUM_LINES-1:0] edge_evt = (s2 & ~prev & ~mre) | (~s2 & prev & ~mfe);
  wire [NUM_LINES-1:0] lvl_evt  = (s2 & ~mre) | (~s2 & ~mfe);
  wire [NUM_LINES-1:0] evt      = (~lvl & edge_evt) | (lvl & lvl_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= irq_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= '0;
      mre     <= '1;
      mfe     <= '1;
      pend    <= '0;
      blk_sel <= '0;
    end else begin
      if (sel_wr) blk_sel <= wdata[BW-1:0];
      lvl  <= (lvl & ~hit) | (hit & {NUM_LINES{wdata[0]}});
      mfe  <= (mfe & ~hit) | (hit & {NUM_LINES{wdata[1]}});
      mre  <= (mre & ~hit) | (hit & {NUM_LINES{wdata[2]}});
      pend <= (pend | evt) & ~clr;
    end
  end

  for (genvar b = 0; b < NMST * 8; b++) begin : g_blk
    if (b < NBLK) begin : g_used
      assign blk_any[b] = |live[b*8 +: 8];
    end else begin : g_pad
      assign blk_any[b] = 1'b0;
    end
  end

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    assign mst[m] = |blk_any[m*8 +: 8];
  end

  assign irq_out = |mst;

  always_comb begin
    rdata = '0;
    if (addr == BASE)        rdata = 8'({mst, 1'b0});
    else if (addr == A_SEL)  rdata = 8'(blk_sel);
    else if (addr == A_PEND) rdata = pend[{blk_sel, 3'b000} +: 8];
    else if (addr == A_RT)   rdata = s2[{blk_sel, 3'b000} +: 8];
    else begin
      for (int m = 0; m < NMST; m++)
        if (addr == BASE + 10'(m + 1)) rdata = blk_any[m*8 +: 8];
    end
  end
endmodule

module irq_tree_agg_chk #(
  parameter int         NUM_LINES = 256,
  parameter logic [9:0] BASE      = 10'h1BB
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [9:0]           addr,
  input logic                 wr_en,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] mre,
  input logic [NUM_LINES-1:0] mfe,
  input logic [((NUM_LINES/8) > 1 ? $clog2(NUM_LINES/8) : 1)-1:0] blk_sel
);
  localparam int BW = ((NUM_LINES/8) > 1) ? $clog2(NUM_LINES/8) : 1;
  localparam logic [9:0] A_SEL = BASE + 10'd5;
  localparam logic [9:0] A_CFG = BASE + 10'd7;
  localparam logic [9:0] A_RT  = BASE + 10'd8;

  wire                 c_clr  = wr_en && addr == A_CFG && wdata[7] && wdata[3];
  wire [BW+2:0]        c_idx  = {blk_sel, wdata[6:4]};
  wire [NUM_LINES-1:0] c_clrv = c_clr ? (NUM_LINES'(1) << c_idx) : '0;

  assert_root_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == BASE) |-> (rdata[0] == 1'b0));
  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < BASE || addr > A_RT) |-> (rdata == 8'h00));
  assert_sel_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEL) |=> (blk_sel == $past(wdata[BW-1:0])));
  assert_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG && !wdata[7]) |=> ($stable(mre) && $stable(mfe)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> (pend[$past(c_idx)] == 1'b0));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(c_clrv)) == '0));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq_out);
endmodule

bind irq_tree_agg irq_tree_agg_chk #(.NUM_LINES(NUM_LINES), .BASE(BASE)) u_chk (.*);

// File: tb/irq_tree_agg_bench.sv
module irq_tree_agg_bench;
  localparam int N = 256;
  localparam logic [9:0] BASE = 10'h1BB;
  localparam logic [9:0] A_SEL = BASE + 10'd5, A_PEND = BASE + 10'd6;
  localparam logic [9:0] A_CFG = BASE + 10'd7, A_RT = BASE + 10'd8;

  logic clk = 0, rst_n = 0, wr_en = 0, irq_out;
  logic [N-1:0] irq_in = '0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  bit [N-1:0] m_lvl, m_mre, m_mfe, m_pend, m_in;

  irq_tree_agg #(.NUM_LINES(N), .BASE(BASE)) u_irq_tree_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  function automatic bit blk_live(int b);
    return |(m_pend[b*8 +: 8] & ~(m_mre[b*8 +: 8] & m_mfe[b*8 +: 8]));
  endfunction
  function automatic [7:0] exp_mst(int m);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = blk_live(m*8 + i);
    return v;
  endfunction
  function automatic [7:0] exp_root();
    logic [7:0] v = '0;
    for (int m = 0; m < 4; m++) v[m+1] = |exp_mst(m);
    return v;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic apply_level();
    for (int i = 0; i < N; i++)
      if (m_lvl[i] && ((m_in[i] && !m_mre[i]) || (!m_in[i] && !m_mfe[i]))) m_pend[i] = 1;
  endtask

  task automatic cfg(int line, bit lv, bit fm, bit rm, bit cl, bit en = 1);
    logic [2:0] bi = 3'(line % 8);
    wr(A_SEL, 8'(line / 8));
    wr(A_CFG, {en, bi, cl, rm, fm, lv});
    if (en) begin
      m_lvl[line] = lv; m_mfe[line] = fm; m_mre[line] = rm;
      if (cl) m_pend[line] = 0;
    end
    repeat (3) @(negedge clk);
    apply_level();
  endtask

  task automatic drive(logic [N-1:0] nv);
    for (int i = 0; i < N; i++)
      if (!m_lvl[i] && nv[i] != m_in[i])
        if ((nv[i] && !m_mre[i]) || (!nv[i] && !m_mfe[i])) m_pend[i] = 1;
    m_in = nv;
    @(negedge clk); irq_in = nv;
    repeat (5) @(negedge clk);
    apply_level();
  endtask

  task automatic full_check(string tag);
    logic [7:0] d;
    for (int b = 0; b < N/8; b++) begin
      wr(A_SEL, 8'(b));
      rd(A_PEND, d); check({tag, " R11 pending"}, d, m_pend[b*8 +: 8]);
      rd(A_RT, d);   check({tag, " R10 live level"}, d, m_in[b*8 +: 8]);
    end
    for (int m = 0; m < 4; m++) begin
      rd(BASE + 10'(m + 1), d); check({tag, " R9 master"}, d, exp_mst(m));
    end
    rd(BASE, d); check({tag, " R9 root"}, d, exp_root());
    check({tag, " R9 irq_out"}, {7'd0, irq_out}, {7'd0, |exp_root()});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [N-1:0] nv;
    int seed_dummy;
    m_lvl = '0; m_mre = '1; m_mfe = '1; m_pend = '0; m_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_SEL, d);  check("R1 block select", d, 8'h00);
    rd(A_PEND, d); check("R1 pending block0", d, 8'h00);
    rd(BASE, d);   check("R1 root", d, 8'h00);
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    // R1 all lines masked: an edge sets nothing
    drive(N'(1) << 17);
    full_check("R1");

    // R2 outside window
    rd(BASE - 10'd1, d); check("R2 below window", d, 8'h00);
    rd(BASE + 10'd9, d); check("R2 above window", d, 8'h00);
    rd(10'h3FF, d);      check("R2 top address", d, 8'h00);
    rd(10'h000, d);      check("R2 address zero", d, 8'h00);

    // R3 block select readback
    wr(A_SEL, 8'd19); rd(A_SEL, d); check("R3 select readback", d, 8'd19);

    // R4 config without enable bit: would unmask both edges of line 0
    cfg(0, 0, 0, 0, 0, 0);
    drive(m_in | N'(1));
    wr(A_SEL, 8'd0); rd(A_PEND, d); check("R4 ignored write", d, 8'h00);

    // R5 rising edge on line 3, no new event on fall
    cfg(3, 0, 1, 0, 1);
    drive(m_in | (N'(1) << 3));
    wr(A_SEL, 8'd0); rd(A_PEND, d); check("R5 rising edge", d, 8'h08);
    drive(m_in & ~(N'(1) << 3));
    cfg(3, 0, 1, 0, 1);
    wr(A_SEL, 8'd0); rd(A_PEND, d); check("R7 clear line3", d, 8'h00);
    // R5 both edges on line 9, falling direction
    cfg(9, 0, 0, 0, 1);
    drive(m_in | (N'(1) << 9));
    cfg(9, 0, 0, 0, 1);
    drive(m_in & ~(N'(1) << 9));
    wr(A_SEL, 8'd1); rd(A_PEND, d); check("R5 falling edge both mode", d, 8'h02);
    rd(BASE + 10'd1, d); check("R9 master0 block1", d, 8'h02);

    // R6 level high on line 20: re-pends after clear
    cfg(20, 1, 1, 0, 1);
    drive(m_in | (N'(1) << 20));
    cfg(20, 1, 1, 0, 1);
    wr(A_SEL, 8'd2); rd(A_PEND, d); check("R6 level re-pend", d, 8'h10);
    drive(m_in & ~(N'(1) << 20));
    cfg(20, 1, 1, 0, 1);
    wr(A_SEL, 8'd2); rd(A_PEND, d); check("R6 level cleared when idle", d, 8'h00);
    // R6 active-low on line 21 (input idle low)
    cfg(21, 1, 0, 1, 1);
    wr(A_SEL, 8'd2); rd(A_PEND, d); check("R6 active-low", d, 8'h20);

    // R8 full mask hides from tree but live level visible
    cfg(255, 0, 1, 0, 1);
    drive(m_in | (N'(1) << 255));
    rd(BASE, d); check("R9 root master3", d, exp_root());
    cfg(255, 0, 1, 1, 0);
    wr(A_SEL, 8'd31);
    rd(A_PEND, d); check("R8 pending kept", d, 8'h80);
    rd(A_RT, d);   check("R8 live level", d, 8'h80);
    rd(BASE + 10'd4, d); check("R8 master3 quiet", d, 8'h00);
    full_check("R8");

    // random phase
    seed_dummy = $urandom(32'h5EED1234);
    for (int it = 0; it < 30; it++) begin
      for (int k = 0; k < 3; k++) begin
        int ln = $urandom % N;
        int r  = $urandom;
        cfg(ln, r[0], r[1], r[2], r[3]);
      end
      nv = m_in;
      for (int k = 0; k < 4; k++) nv[$urandom % N] ^= 1'b1;
      drive(nv);
      full_check("rand R5 R6 R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule